// File: doc/BRIEF.md
# Instruction Cache Range Invalidator

This block clears a span of addresses from an instruction cache by driving an area-invalidation engine. A requester hands over a start address and an exclusive end address with a valid/ready handshake. The block picks one power-of-two block size that is large enough to cover the span and programs the engine's mask once. It then sends invalidate commands at block-aligned addresses, one after another, until the address reaches the end. Before it writes the mask, and after every command, it waits for the engine's busy flag to drop.

If the cache enable input is low when the request is taken, the request ends at once and the engine is never touched. Because the first address is the start rounded down to the block size, a start that is not aligned can add one trailing command. Every line in the span is still covered. The caller must supply an end address above the start.

The sequencer has six states. IDLE takes a request (go to DRAIN, or to FINISH if the cache is disabled). DRAIN waits for the engine to become idle (go to MASK). MASK writes the mask (go to ISSUE). ISSUE sends one command (go to WAIT). WAIT holds until the engine is idle, then advances the address and goes back to ISSUE while the address is below the end, or else to FINISH. FINISH pulses done (go to IDLE).

Top module: `icache_range_inv`

## Requirements
- R1: If cache_en is low when a request is accepted, done is high in the cycle after acceptance, and no mask or command strobe occurs for that request.
- R2: The block size begins at LINE_BYTES and doubles once for each right shift needed to bring ((end - start - 1) >> log2(LINE_BYTES)) to zero. The mask written is the bitwise NOT of (block size - 1).
- R3: The mask strobe is never asserted while eng_busy is high. The mask is written only after eng_busy has been seen low.
- R4: Each enabled request writes the mask exactly once.
- R5: The first command address is start AND mask, and it is issued in the cycle right after the mask strobe.
- R6: Each command word is the aligned address with bit 0 (the invalidate bit) set. No command is issued while eng_busy is high. The engine must raise busy in the cycle after a command strobe.
- R7: Each command address is the previous one plus the block size. Commands continue while the next address is below end. The expected command counts come from this rule.
- R8: Every LINE_BYTES line that overlaps [start, end) lies inside a block that was sent a command.
- R9: req_ready is high only in IDLE, so requests are refused while an operation runs. done is a single-cycle pulse, and req_ready returns in the following cycle.
- R10: mask_wr, cmd_wr and done are single-cycle strobes, and no two of them are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Instruction cache enabled; sampled when a request is accepted |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_start | input | ADDR_W | First byte address of the span |
| req_end | input | ADDR_W | Address one past the last byte of the span |
| done | output | 1 | One-cycle completion pulse |
| eng_busy | input | 1 | Invalidation engine busy |
| mask_wr | output | 1 | Mask register write strobe |
| mask_data | output | ADDR_W | Mask value, valid with mask_wr |
| cmd_wr | output | 1 | Command register write strobe |
| cmd_data | output | ADDR_W | Aligned address with the invalidate bit (bit 0) set, valid with cmd_wr |

## Verification
The bench uses the defaults ADDR_W = 32 and LINE_BYTES = 16. With these values, block sizes from a single 16-byte line up to 4096 bytes can be reached from short spans. The 16-byte line leaves bit 0 free for the invalidate flag. The vectors include spans that are aligned and spans that are not, so both single-command and extra-trailing-command cases occur. The engine model can hold busy high before a request and uses different busy lengths after each command.

// File: rtl/icri_pkg.sv
package icri_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_MASK,
        ST_ISSUE,
        ST_WAIT,
        ST_FINISH
    } icri_state_e;
endpackage

// File: rtl/icri_size_calc.sv
module icri_size_calc #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic [ADDR_W-1:0] span_start,
    input  logic [ADDR_W-1:0] span_end,
    output logic [ADDR_W:0]   blk_size,
    output logic [ADDR_W-1:0] blk_mask
);
    localparam int LINE_SHIFT = $clog2(LINE_BYTES);
    localparam int NB_W       = $clog2(ADDR_W + 1);

    logic [ADDR_W-1:0] lines_m1;
    logic [NB_W-1:0]   n_bits;
    logic [ADDR_W-1:0] size_m1;

    assign lines_m1 = (span_end - span_start - ADDR_W'(1)) >> LINE_SHIFT;

    // one doubling per significant bit of the line count
    always_comb begin
        n_bits = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (lines_m1[i]) n_bits = NB_W'(i + 1);
        end
    end

    assign blk_size = (ADDR_W+1)'(LINE_BYTES) << n_bits;
    assign size_m1  = blk_size[ADDR_W-1:0] - ADDR_W'(1);
    assign blk_mask = ~size_m1;
endmodule

// File: rtl/icri_seq.sv
module icri_seq
    import icri_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic              done,
    input  logic              eng_busy,
    output logic              mask_wr,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] lat_start,
    output logic [ADDR_W-1:0] lat_end,
    input  logic [ADDR_W:0]   blk_size,
    input  logic [ADDR_W-1:0] blk_mask
);
    icri_state_e state, state_nx;
    logic [ADDR_W:0] addr_q;
    logic [ADDR_W:0] addr_nx;
    logic            accept;
    logic            more;

    assign accept  = req_valid && (state == ST_IDLE);
    assign addr_nx = addr_q + blk_size;
    assign more    = addr_nx < {1'b0, lat_end};
    assign cur_addr = addr_q[ADDR_W-1:0];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = cache_en ? ST_DRAIN : ST_FINISH;
            ST_DRAIN:  if (!eng_busy) state_nx = ST_MASK;
            ST_MASK:   state_nx = ST_ISSUE;
            ST_ISSUE:  state_nx = ST_WAIT;
            ST_WAIT:   if (!eng_busy) state_nx = more ? ST_ISSUE : ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        req_ready = 1'b0;
        mask_wr   = 1'b0;
        cmd_wr    = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_MASK:   mask_wr   = 1'b1;
            ST_ISSUE:  cmd_wr    = 1'b1;
            ST_FINISH: done      = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_start <= '0;
            lat_end   <= '0;
            addr_q    <= '0;
        end else begin
            if (accept) begin
                lat_start <= req_start;
                lat_end   <= req_end;
            end
            if (state == ST_MASK)
                addr_q <= {1'b0, lat_start & blk_mask};
            else if (state == ST_WAIT && !eng_busy)
                addr_q <= addr_nx;
        end
    end

    // R3: mask goes out only to an idle engine
    a_r3_mask_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |-> !eng_busy);
    // R6: commands go out only to an idle engine
    a_r6_cmd_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> !eng_busy);
    // R4: one mask write, immediately followed by the first command (R5)
    a_r4_mask_once: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> !mask_wr);
    a_r5_cmd_after_mask: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> cmd_wr);
    // R10: strobes never overlap
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mask_wr, cmd_wr, done}));
    // R9: ready returns after done, and done lasts one cycle
    a_r9_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));
    // R1: a disabled request completes on the next cycle
    a_r1_disabled_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !cache_en) |=> done);
endmodule

// File: rtl/icache_range_inv.sv
module icache_range_inv #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic              done,
    input  logic              eng_busy,
    output logic              mask_wr,
    output logic [ADDR_W-1:0] mask_data,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_data
);
    localparam logic [ADDR_W-1:0] INV_BIT = ADDR_W'(1);

    logic [ADDR_W-1:0] lat_start, lat_end, cur_addr, blk_mask;
    logic [ADDR_W:0]   blk_size;

    icri_size_calc #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_calc (
        .span_start (lat_start),
        .span_end   (lat_end),
        .blk_size   (blk_size),
        .blk_mask   (blk_mask)
    );

    icri_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cache_en  (cache_en),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_start (req_start),
        .req_end   (req_end),
        .done      (done),
        .eng_busy  (eng_busy),
        .mask_wr   (mask_wr),
        .cmd_wr    (cmd_wr),
        .cur_addr  (cur_addr),
        .lat_start (lat_start),
        .lat_end   (lat_end),
        .blk_size  (blk_size),
        .blk_mask  (blk_mask)
    );

    assign mask_data = blk_mask;
    assign cmd_data  = cur_addr | INV_BIT;

    // R6: command word carries the invalidate bit
    a_r6_inv_bit: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> cmd_data[0]);
    // R7: command addresses are aligned to the programmed block
    a_r7_cmd_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> (((cmd_data & ~INV_BIT) & ~blk_mask) == '0));
endmodule

// File: tb/test_icache_range_inv.sv
module test_icache_range_inv;
    localparam int NV = 8;
    localparam logic [31:0] V_START [NV] = '{32'h1000, 32'h1010, 32'h2000, 32'h2005,
                                             32'h3000, 32'h30F0, 32'h1000, 32'h5008};
    localparam logic [31:0] V_END   [NV] = '{32'h1040, 32'h1050, 32'h2010, 32'h2006,
                                             32'h4000, 32'h3110, 32'h2000, 32'h5100};
    localparam logic        V_EN    [NV] = '{1, 1, 1, 1, 1, 1, 0, 1};
    localparam int          V_PRE   [NV] = '{0, 3, 0, 5, 1, 0, 2, 4};
    localparam int          V_LAT   [NV] = '{1, 2, 3, 1, 4, 2, 1, 3};
    localparam logic [31:0] V_MASK  [NV] = '{32'hFFFFFFC0, 32'hFFFFFFC0, 32'hFFFFFFF0, 32'hFFFFFFF0,
                                             32'hFFFFF000, 32'hFFFFFFE0, 32'h0, 32'hFFFFFF00};
    localparam int          V_NCMD  [NV] = '{1, 2, 1, 1, 1, 2, 0, 1};
    localparam logic [31:0] V_FIRST [NV] = '{32'h1000, 32'h1000, 32'h2000, 32'h2000,
                                             32'h3000, 32'h30E0, 32'h0, 32'h5000};

    logic clk = 0, rst_n = 0, cache_en = 0, req_valid = 0;
    logic [31:0] req_start = 0, req_end = 0;
    logic req_ready, done, eng_busy, mask_wr, cmd_wr;
    logic [31:0] mask_data, cmd_data;
    logic pre_busy = 0;
    int   lat = 1;
    int   rcnt;
    int   errors = 0, checks = 0, cycles = 0;
    int   n_mask = 0, n_cmd = 0, busy_viol = 0;
    logic [31:0] last_mask;
    logic [31:0] cmds [16];

    always #2 clk = ~clk;

    icache_range_inv i_icache_range_inv (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .req_valid(req_valid),
        .req_ready(req_ready), .req_start(req_start), .req_end(req_end), .done(done),
        .eng_busy(eng_busy), .mask_wr(mask_wr), .mask_data(mask_data),
        .cmd_wr(cmd_wr), .cmd_data(cmd_data));

    // engine model: busy for lat cycles after each command
    always @(posedge clk) begin
        if (!rst_n) rcnt <= 0;
        else if (cmd_wr) rcnt <= lat;
        else if (rcnt != 0) rcnt <= rcnt - 1;
    end
    assign eng_busy = (rcnt != 0) || pre_busy;

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (mask_wr) begin
            n_mask <= n_mask + 1;
            last_mask <= mask_data;
            if (eng_busy) busy_viol <= busy_viol + 1;
        end
        if (cmd_wr) begin
            if (n_cmd < 16) cmds[n_cmd] <= cmd_data;
            n_cmd <= n_cmd + 1;
            if (eng_busy) busy_viol <= busy_viol + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // issue a request and wait for done; returns cycles from acceptance to done
    task automatic run(input logic [31:0] s, input logic [31:0] e, input logic en,
                       input int pre, input int l, output int dly);
        int k;
        @(negedge clk);
        n_mask = 0; n_cmd = 0; busy_viol = 0;
        lat = l; pre_busy = (pre != 0);
        req_start = s; req_end = e; cache_en = en; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        dly = 0; k = 0;
        while (!done) begin
            dly++; k++;
            if (k >= pre) pre_busy = 0;
            if (dly > 5000) begin
                chk(0, "watchdog", 32'(dly), 0);
                finish_run();
            end
            @(negedge clk);
        end
        dly++;
        pre_busy = 0;
        @(negedge clk);
        chk(done == 0, "R9 done single cycle", 32'(done), 0);
        chk(req_ready == 1, "R9 ready after done", 32'(req_ready), 1);
    endtask

    initial begin
        int dly;
        repeat (3) @(negedge clk);
        chk(req_ready == 1 && !mask_wr && !cmd_wr && !done, "reset state",
            {mask_wr, cmd_wr, done, req_ready}, 32'h1);
        rst_n = 1;

        for (int v = 0; v < NV; v++) begin
            run(V_START[v], V_END[v], V_EN[v], V_PRE[v], V_LAT[v], dly);
            if (!V_EN[v]) begin
                chk(dly == 1, "R1 disabled latency", 32'(dly), 1);
                chk(n_mask == 0 && n_cmd == 0, "R1 no engine activity", 32'(n_mask + n_cmd), 0);
            end else begin
                chk(n_mask == 1, "R4 mask count", 32'(n_mask), 1);
                chk(last_mask == V_MASK[v], "R2 mask value", last_mask, V_MASK[v]);
                chk(busy_viol == 0, "R3 R6 strobe while busy", 32'(busy_viol), 0);
                chk(n_cmd == V_NCMD[v], "R7 command count", 32'(n_cmd), 32'(V_NCMD[v]));
                chk(cmds[0] == (V_FIRST[v] | 32'h1), "R5 first command", cmds[0], V_FIRST[v] | 32'h1);
                for (int c = 0; c < n_cmd && c < 16; c++) begin
                    chk(cmds[c][0] == 1'b1, "R6 invalidate bit", cmds[c], cmds[c] | 32'h1);
                    if (c > 0)
                        chk(cmds[c] - cmds[c-1] == ~V_MASK[v] + 1, "R7 stride",
                            cmds[c] - cmds[c-1], ~V_MASK[v] + 1);
                end
                for (logic [31:0] ln = V_START[v] & 32'hFFFFFFF0; ln < V_END[v]; ln += 16) begin
                    bit hit = 0;
                    for (int c = 0; c < n_cmd && c < 16; c++) begin
                        logic [31:0] b;
                        b = cmds[c] & ~32'h1;
                        if (ln >= b && ln - b < ~V_MASK[v] + 1) hit = 1;
                    end
                    chk(hit, "R8 line covered", ln, ln);
                end
            end
        end

        // R9: a request held during an operation is refused
        @(negedge clk);
        n_cmd = 0; lat = 2;
        req_start = 32'h6000; req_end = 32'h6020; cache_en = 1; req_valid = 1;
        @(negedge clk);
        req_start = 32'h7000; req_end = 32'h7400;
        chk(req_ready == 0, "R9 ready low while running", 32'(req_ready), 0);
        while (!done) @(negedge clk);
        req_valid = 0;
        repeat (20) @(negedge clk);
        chk(n_cmd == 1, "R9 second request ignored", 32'(n_cmd), 1);
        chk(cmds[0] == 32'h6001, "R9 first request served", cmds[0], 32'h6001);

        // R10: strobes are one cycle wide
        @(negedge clk);
        lat = 1; req_start = 32'h8000; req_end = 32'h8100; cache_en = 1; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        while (!mask_wr) @(negedge clk);
        @(negedge clk);
        chk(!mask_wr && cmd_wr, "R10 mask one cycle then command", {mask_wr, cmd_wr}, 32'h1);
        @(negedge clk);
        chk(!cmd_wr, "R10 command one cycle", 32'(cmd_wr), 0);
        while (!done) @(negedge clk);
        @(negedge clk);

        finish_run();
    end

    initial begin
        #800000;
        chk(0, "watchdog", 32'(cycles), 0);
        finish_run();
    end
endmodule